// File: doc/BRIEF.md
# Power-Manager Operating-Mode Controller

This block is the mode sequencer of a multi-rail power manager. It takes status inputs that other logic has already qualified: the three cold-reset causes (power-on reset, thermal shutdown, loss of the low-power clock), the configuration checksum and regulator self-test results, per-rail over-voltage and under-voltage monitors, loss of ground, over-temperature, the temperature-sense window, the wake level, watchdog violations and two decoded host commands (sleep and lock). From these it walks the device through initialisation, a two-step comparator self-test, a temperature-window check and a sequenced rail ramp before it reaches normal operation.

A 3-bit persistent-fault counter records every warm reset event. When the count would reach a parameter limit, the controller stops retrying. It drops into low-power mode, clears the counter and raises an overflow flag, which the register block clears with a read strobe. Each start-up state is bounded by a timeout. A stretched main reset output keeps the processor held for a hold time after normal operation begins and after each watchdog hit.

Top module: `pm_mode_top`

## Requirements
- R1: After reset the mode output is INIT (mode codes: INIT=0, SELFTEST_ALL=1, SELFTEST_UV=2, TEMPCHECK=3, RAMP=4, ACTIVE=5, FAULT=6, SLEEP=7, LOCKED=8, SHUTDOWN=9). The error count is 0, every rail enable is low and resetN is low. INIT moves to SELFTEST_ALL once cfgOk and vregUvSelf are both high.
- R2: SELFTEST_ALL advances to SELFTEST_UV only in a cycle where every bit of ovFlags and every bit of uvFlags is 1 (bit i belongs to rail i).
- R3: In SELFTEST_UV, any ovFlags bit or overTemp holds the state. Without either, the next state is TEMPCHECK, whatever uvFlags shows.
- R4: In each of SELFTEST_ALL, SELFTEST_UV, TEMPCHECK and RAMP, once START_TMO cycles have been spent in the state and wake is low, the controller goes to SLEEP. While wake is high the state is held.
- R5: In TEMPCHECK, over-voltage, loss of ground or over-temperature is a fault event. Otherwise, with neither vtLow nor vtHigh set, the controller enters RAMP.
- R6: In RAMP, rail1En rises on entry. rail2En and boostEn rise once SEQ2_DLY cycles have passed and rail1Ok is high. rail3En rises SEQ1_DLY cycles after that. One cycle later the mode becomes ACTIVE.
- R7: A fault event (in TEMPCHECK or RAMP: over-voltage, ground loss, over-temperature; in ACTIVE these or any under-voltage) increments the error count and enters FAULT, provided the limit is not reached. FAULT returns to SELFTEST_ALL once there is no over-voltage, ground loss or over-temperature.
- R8: An increment that would make the count equal EC_LIMIT instead enters SLEEP, clears the count and sets ecOvf. ovfRead clears ecOvf.
- R9: In ACTIVE, cmdSleep enters SLEEP and decrements the count, saturating at 0. cmdLock enters LOCKED, which only a cold-reset cause can leave.
- R10: In ACTIVE, wdViol increments the error count and leaves the mode in ACTIVE, unless the limit is reached.
- R11: vtLow in ACTIVE, or vtHigh in RAMP, returns the controller to SELFTEST_ALL.
- R12: SLEEP is left for SELFTEST_ALL only after wake has been high on WAKE_MIN consecutive clock edges. Wake has no effect in LOCKED.
- R13: Any of porReq, thermShut or lpClkLost forces SHUTDOWN from every state and clears the count and ecOvf. SHUTDOWN moves to INIT once all three are low.
- R14: resetN is high only in ACTIVE, and only after RST_HOLD cycles have passed since ACTIVE was entered or since the last watchdog event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porReq | input | 1 | Power-on reset cause |
| thermShut | input | 1 | Thermal shutdown cause |
| lpClkLost | input | 1 | Low-power clock lost |
| cfgOk | input | 1 | Configuration checksum valid |
| vregUvSelf | input | 1 | Regulator monitor self-test reports undervoltage |
| ovFlags | input | NRAIL | Over-voltage comparator per rail |
| uvFlags | input | NRAIL | Under-voltage comparator per rail |
| gndLoss | input | 1 | Loss of ground detected |
| overTemp | input | 1 | Regulator over-temperature |
| vtLow | input | 1 | Temperature-sense input below window |
| vtHigh | input | 1 | Temperature-sense input above window |
| rail1Ok | input | 1 | Rail 1 above its undervoltage level |
| wake | input | 1 | Wake level |
| wdViol | input | 1 | Watchdog violation strobe |
| cmdSleep | input | 1 | Decoded sleep command strobe |
| cmdLock | input | 1 | Decoded lock command strobe |
| ovfRead | input | 1 | Read strobe that clears the overflow flag |
| mode | output | 4 | Current mode code |
| rail1En | output | 1 | Rail 1 enable |
| rail2En | output | 1 | Rail 2 enable |
| boostEn | output | 1 | Boost rail enable |
| rail3En | output | 1 | Rail 3 enable |
| resetN | output | 1 | Stretched main reset, active low |
| ecCount | output | 3 | Error counter value |
| ecOvf | output | 1 | Error counter overflow flag |

## Verification
The bench targets the following corner cases:
- A self-test state fed a partial pass/fail pattern. A design that advanced on one comparator group alone would leave SELFTEST_ALL early.
- The increment that reaches the limit, including a watchdog hit in ACTIVE. A design that compared after incrementing would show a count of EC_LIMIT or stay in FAULT instead of entering SLEEP with the flag set.
- A timeout that expires while wake is high. An incorrect design would drop to SLEEP here.
- A short wake pulse in SLEEP and a long wake in LOCKED. An unfiltered or unmasked wake would restart the sequence.
- Rail 1 held below its level past the ramp delay. This exposes a design that started rail 2 on time alone.

// File: rtl/pm_mode_pkg.sv
package pm_mode_pkg;

  typedef enum logic [3:0] {
    MD_INIT      = 4'd0,
    MD_SELF_ALL  = 4'd1,
    MD_SELF_UV   = 4'd2,
    MD_TEMPCHK   = 4'd3,
    MD_RAMP      = 4'd4,
    MD_ACTIVE    = 4'd5,
    MD_FAULT     = 4'd6,
    MD_SLEEP     = 4'd7,
    MD_LOCKED    = 4'd8,
    MD_SHUTDOWN  = 4'd9
  } pmMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;   // state changes this edge
    logic seqClr;   // ramp step advances this edge
    logic ecInc;    // warm reset event
    logic ecDec;    // sleep command
    logic ecClr;    // cold reset cause
    logic rstKick;  // reload reset hold
  } pmStrobe_t;

  localparam int EC_W = 3;

endpackage

// File: rtl/pm_mode_dp.sv
module pm_mode_dp
  import pm_mode_pkg::*;
#(
  parameter int EC_LIMIT  = 4,
  parameter int START_TMO = 40,
  parameter int SEQ2_DLY  = 6,
  parameter int SEQ1_DLY  = 5,
  parameter int WAKE_MIN  = 4,
  parameter int RST_HOLD  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pmStrobe_t       strb,
  input  logic            wake,
  input  logic            ovfRead,
  output logic            tmoHit,
  output logic            seq2Done,
  output logic            seq1Done,
  output logic            wakeOk,
  output logic            ecAtLimit,
  output logic            holdDone,
  output logic [EC_W-1:0] ecCount,
  output logic            ecOvf
);

  localparam int SEQ_MAX = (SEQ2_DLY > SEQ1_DLY) ? SEQ2_DLY : SEQ1_DLY;
  localparam int TMR_W   = $clog2(START_TMO + 1);
  localparam int SEQ_W   = $clog2(SEQ_MAX + 1);
  localparam int WAKE_W  = $clog2(WAKE_MIN + 1);
  localparam int HOLD_W  = $clog2(RST_HOLD + 1);

  logic [TMR_W-1:0]  stateTmr;
  logic [SEQ_W-1:0]  seqTmr;
  logic [WAKE_W-1:0] wakeCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [EC_W-1:0]   ecCnt;
  logic              ovfFlag;

  assign tmoHit    = (stateTmr == TMR_W'(START_TMO));
  assign seq2Done  = (seqTmr >= SEQ_W'(SEQ2_DLY));
  assign seq1Done  = (seqTmr >= SEQ_W'(SEQ1_DLY));
  assign wakeOk    = (wakeCnt == WAKE_W'(WAKE_MIN));
  assign ecAtLimit = (ecCnt == EC_W'(EC_LIMIT - 1));
  assign holdDone  = (holdCnt == '0);
  assign ecCount   = ecCnt;
  assign ecOvf     = ovfFlag;

  // timers: time in state and time in ramp step, both saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateTmr <= '0;
      seqTmr   <= '0;
    end else begin
      if (strb.tmrClr)          stateTmr <= '0;
      else if (!tmoHit)         stateTmr <= stateTmr + 1'b1;
      if (strb.tmrClr || strb.seqClr) seqTmr <= '0;
      else if (seqTmr != SEQ_W'(SEQ_MAX)) seqTmr <= seqTmr + 1'b1;
    end
  end

  // wake pulse-width filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wakeCnt <= '0;
    else if (!wake)    wakeCnt <= '0;
    else if (!wakeOk)  wakeCnt <= wakeCnt + 1'b1;
  end

  // main reset hold stretch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             holdCnt <= HOLD_W'(RST_HOLD);
    else if (strb.rstKick)  holdCnt <= HOLD_W'(RST_HOLD);
    else if (!holdDone)     holdCnt <= holdCnt - 1'b1;
  end

  // persistent-fault counter and overflow flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecCnt   <= '0;
      ovfFlag <= 1'b0;
    end else if (strb.ecClr) begin
      ecCnt   <= '0;
      ovfFlag <= 1'b0;
    end else if (strb.ecInc) begin
      if (ecAtLimit) begin
        ecCnt   <= '0;
        ovfFlag <= 1'b1;
      end else begin
        ecCnt   <= ecCnt + 1'b1;
        if (ovfRead) ovfFlag <= 1'b0;
      end
    end else begin
      if (strb.ecDec && ecCnt != '0) ecCnt <= ecCnt - 1'b1;
      if (ovfRead) ovfFlag <= 1'b0;
    end
  end

  AST_EC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ecCnt < EC_W'(EC_LIMIT)); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ovfRead && !strb.ecInc |=> !ovfFlag); // R8
  AST_HOLD_AFTER_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rstKick |=> !holdDone); // R14

endmodule

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl
  import pm_mode_pkg::*;
#(
  parameter int NRAIL = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coldReq,
  input  logic             cfgOk,
  input  logic             vregUvSelf,
  input  logic [NRAIL-1:0] ovFlags,
  input  logic [NRAIL-1:0] uvFlags,
  input  logic             gndLoss,
  input  logic             overTemp,
  input  logic             vtLow,
  input  logic             vtHigh,
  input  logic             rail1Ok,
  input  logic             wake,
  input  logic             wdViol,
  input  logic             cmdSleep,
  input  logic             cmdLock,
  input  logic             tmoHit,
  input  logic             seq2Done,
  input  logic             seq1Done,
  input  logic             wakeOk,
  input  logic             ecAtLimit,
  input  logic             holdDone,
  output pmStrobe_t        strb,
  output pmMode_t          state,
  output logic             rail1En,
  output logic             rail2En,
  output logic             boostEn,
  output logic             rail3En,
  output logic             resetN
);

  pmMode_t    nxt;
  logic [1:0] step, nStep;
  logic       faultHard, faultAct, stuckTmo, wdEvt;

  assign faultHard = (|ovFlags) | gndLoss | overTemp;
  assign faultAct  = faultHard | (|uvFlags);
  assign stuckTmo  = tmoHit && !wake;

  always_comb begin
    nxt   = state;
    nStep = step;
    wdEvt = 1'b0;
    strb  = '0;
    unique case (state)
      MD_SHUTDOWN: nxt = MD_INIT;
      MD_INIT:     if (cfgOk && vregUvSelf) nxt = MD_SELF_ALL;
      MD_SELF_ALL: begin
        if ((&ovFlags) && (&uvFlags)) nxt = MD_SELF_UV;
        else if (stuckTmo)            nxt = MD_SLEEP;
      end
      MD_SELF_UV: begin
        if (!(|ovFlags) && !overTemp) nxt = MD_TEMPCHK;
        else if (stuckTmo)            nxt = MD_SLEEP;
      end
      MD_TEMPCHK: begin
        if (faultHard) begin
          strb.ecInc = 1'b1;
          nxt = ecAtLimit ? MD_SLEEP : MD_FAULT;
        end else if (!vtLow && !vtHigh) nxt = MD_RAMP;
        else if (stuckTmo)              nxt = MD_SLEEP;
      end
      MD_RAMP: begin
        if (faultHard) begin
          strb.ecInc = 1'b1;
          nxt = ecAtLimit ? MD_SLEEP : MD_FAULT;
        end else if (vtHigh)   nxt = MD_SELF_ALL;
        else if (stuckTmo)     nxt = MD_SLEEP;
        else if (step == 2'd0) begin
          if (seq2Done && rail1Ok) begin nStep = 2'd1; strb.seqClr = 1'b1; end
        end else if (step == 2'd1) begin
          if (seq1Done) begin nStep = 2'd2; strb.seqClr = 1'b1; end
        end else nxt = MD_ACTIVE;
      end
      MD_ACTIVE: begin
        if (faultAct) begin
          strb.ecInc = 1'b1;
          nxt = ecAtLimit ? MD_SLEEP : MD_FAULT;
        end else if (cmdLock)  nxt = MD_LOCKED;
        else if (cmdSleep) begin
          strb.ecDec = 1'b1;
          nxt = MD_SLEEP;
        end else if (vtLow)    nxt = MD_SELF_ALL;
        else if (wdViol) begin
          wdEvt = 1'b1;
          strb.ecInc = 1'b1;
          if (ecAtLimit) nxt = MD_SLEEP;
        end
      end
      MD_FAULT:  if (!faultHard) nxt = MD_SELF_ALL;
      MD_SLEEP:  if (wakeOk)     nxt = MD_SELF_ALL;
      MD_LOCKED: nxt = MD_LOCKED;
      default:   nxt = MD_SHUTDOWN;
    endcase
    if (coldReq) begin
      nxt        = MD_SHUTDOWN;
      strb.ecInc = 1'b0;
      strb.ecDec = 1'b0;
      strb.ecClr = 1'b1;
      wdEvt      = 1'b0;
    end
    if (nxt != state) nStep = 2'd0;
    strb.tmrClr  = (nxt != state);
    strb.rstKick = (state != MD_ACTIVE) || wdEvt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MD_INIT;
      step  <= 2'd0;
    end else begin
      state <= nxt;
      step  <= nStep;
    end
  end

  assign rail1En = (state == MD_RAMP) || (state == MD_ACTIVE);
  assign rail2En = (state == MD_ACTIVE) || ((state == MD_RAMP) && step != 2'd0);
  assign boostEn = rail2En;
  assign rail3En = (state == MD_ACTIVE) || ((state == MD_RAMP) && step == 2'd2);
  assign resetN  = (state == MD_ACTIVE) && holdDone;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MD_LOCKED) && !coldReq |=> state == MD_LOCKED); // R9
  AST_COLD_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    coldReq |=> state == MD_SHUTDOWN); // R13
  AST_ACTIVE_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == MD_ACTIVE) |-> $past(state) == MD_RAMP); // R6
  AST_RAIL3_AFTER_RAIL2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail3En) && (state == MD_RAMP) |-> $past(rail2En)); // R6

endmodule

// File: rtl/pm_mode_top.sv
module pm_mode_top
  import pm_mode_pkg::*;
#(
  parameter int NRAIL     = 6,
  parameter int EC_LIMIT  = 4,
  parameter int START_TMO = 40,
  parameter int SEQ2_DLY  = 6,
  parameter int SEQ1_DLY  = 5,
  parameter int WAKE_MIN  = 4,
  parameter int RST_HOLD  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             porReq,
  input  logic             thermShut,
  input  logic             lpClkLost,
  input  logic             cfgOk,
  input  logic             vregUvSelf,
  input  logic [NRAIL-1:0] ovFlags,
  input  logic [NRAIL-1:0] uvFlags,
  input  logic             gndLoss,
  input  logic             overTemp,
  input  logic             vtLow,
  input  logic             vtHigh,
  input  logic             rail1Ok,
  input  logic             wake,
  input  logic             wdViol,
  input  logic             cmdSleep,
  input  logic             cmdLock,
  input  logic             ovfRead,
  output logic [3:0]       mode,
  output logic             rail1En,
  output logic             rail2En,
  output logic             boostEn,
  output logic             rail3En,
  output logic             resetN,
  output logic [2:0]       ecCount,
  output logic             ecOvf
);

  pmStrobe_t strb;
  pmMode_t   state;
  logic tmoHit, seq2Done, seq1Done, wakeOk, ecAtLimit, holdDone;

  pm_mode_ctrl #(.NRAIL(NRAIL)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .coldReq(porReq | thermShut | lpClkLost),
    .cfgOk(cfgOk), .vregUvSelf(vregUvSelf), .ovFlags(ovFlags), .uvFlags(uvFlags),
    .gndLoss(gndLoss), .overTemp(overTemp), .vtLow(vtLow), .vtHigh(vtHigh),
    .rail1Ok(rail1Ok), .wake(wake), .wdViol(wdViol), .cmdSleep(cmdSleep),
    .cmdLock(cmdLock), .tmoHit(tmoHit), .seq2Done(seq2Done), .seq1Done(seq1Done),
    .wakeOk(wakeOk), .ecAtLimit(ecAtLimit), .holdDone(holdDone), .strb(strb),
    .state(state), .rail1En(rail1En), .rail2En(rail2En), .boostEn(boostEn),
    .rail3En(rail3En), .resetN(resetN)
  );

  pm_mode_dp #(
    .EC_LIMIT(EC_LIMIT), .START_TMO(START_TMO), .SEQ2_DLY(SEQ2_DLY),
    .SEQ1_DLY(SEQ1_DLY), .WAKE_MIN(WAKE_MIN), .RST_HOLD(RST_HOLD)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wake(wake), .ovfRead(ovfRead),
    .tmoHit(tmoHit), .seq2Done(seq2Done), .seq1Done(seq1Done), .wakeOk(wakeOk),
    .ecAtLimit(ecAtLimit), .holdDone(holdDone), .ecCount(ecCount), .ecOvf(ecOvf)
  );

  assign mode = state;

endmodule

// File: tb/test_pm_mode_top.sv
`timescale 1ns/1ps
module test_pm_mode_top;

  localparam int NRAIL = 6, EC_LIMIT = 4, START_TMO = 40, SEQ2_DLY = 6;
  localparam int SEQ1_DLY = 5, WAKE_MIN = 4, RST_HOLD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic porReq = 0, thermShut = 0, lpClkLost = 0, cfgOk = 0, vregUvSelf = 0;
  logic [NRAIL-1:0] ovFlags = '0, uvFlags = '0;
  logic gndLoss = 0, overTemp = 0, vtLow = 0, vtHigh = 0, rail1Ok = 0, wake = 0;
  logic wdViol = 0, cmdSleep = 0, cmdLock = 0, ovfRead = 0;
  logic [3:0] mode;
  logic rail1En, rail2En, boostEn, rail3En, resetN, ecOvf;
  logic [2:0] ecCount;

  int errors = 0, checks = 0, cycles = 0;
  bit chkEn = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  pm_mode_top i_pm_mode_top (.*);

  // behavioural reference model
  int mSt = 0, mStep = 0, mEc = 0, mOvf = 0, mTmr = 0, mSeq = 0, mWake = 0;
  int mHold = RST_HOLD;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mSt = 0; mStep = 0; mEc = 0; mOvf = 0; mTmr = 0; mSeq = 0; mWake = 0;
      mHold = RST_HOLD;
    end else begin
      int nS, nStep;
      bit cold, hard, act, stuck, inc, dec, sClr, wd, lim;
      cold = porReq | thermShut | lpClkLost;
      hard = (ovFlags != 0) | gndLoss | overTemp;
      act = hard | (uvFlags != 0);
      stuck = (mTmr >= START_TMO) && !wake;
      lim = (mEc == EC_LIMIT - 1);
      nS = mSt; nStep = mStep; inc = 0; dec = 0; sClr = 0; wd = 0;
      if (cold) nS = 9;
      else begin
        case (mSt)
          9: nS = 0;
          0: if (cfgOk && vregUvSelf) nS = 1;
          1: if (ovFlags == '1 && uvFlags == '1) nS = 2; else if (stuck) nS = 7;
          2: if (ovFlags == 0 && !overTemp) nS = 3; else if (stuck) nS = 7;
          3: if (hard) begin inc = 1; nS = lim ? 7 : 6; end
             else if (!vtLow && !vtHigh) nS = 4; else if (stuck) nS = 7;
          4: if (hard) begin inc = 1; nS = lim ? 7 : 6; end
             else if (vtHigh) nS = 1;
             else if (stuck) nS = 7;
             else if (mStep == 0) begin
               if (mSeq >= SEQ2_DLY && rail1Ok) begin nStep = 1; sClr = 1; end
             end else if (mStep == 1) begin
               if (mSeq >= SEQ1_DLY) begin nStep = 2; sClr = 1; end
             end else nS = 5;
          5: if (act) begin inc = 1; nS = lim ? 7 : 6; end
             else if (cmdLock) nS = 8;
             else if (cmdSleep) begin dec = 1; nS = 7; end
             else if (vtLow) nS = 1;
             else if (wdViol) begin wd = 1; inc = 1; if (lim) nS = 7; end
          6: if (!hard) nS = 1;
          7: if (mWake >= WAKE_MIN) nS = 1;
          default: ;
        endcase
      end
      if (cold) begin mEc = 0; mOvf = 0; end
      else if (inc && lim) begin mEc = 0; mOvf = 1; end
      else begin
        if (inc) mEc++;
        else if (dec && mEc > 0) mEc--;
        if (ovfRead) mOvf = 0;
      end
      mHold = (mSt != 5 || wd) ? RST_HOLD : (mHold > 0 ? mHold - 1 : 0);
      mWake = wake ? (mWake < WAKE_MIN ? mWake + 1 : mWake) : 0;
      if (nS != mSt) begin mTmr = 0; mSeq = 0; nStep = 0; end
      else begin
        if (mTmr < START_TMO) mTmr++;
        if (sClr) mSeq = 0;
        else if (mSeq < ((SEQ2_DLY > SEQ1_DLY) ? SEQ2_DLY : SEQ1_DLY)) mSeq++;
      end
      mSt = nS; mStep = nStep;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", curReq, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (chkEn && rst_n) begin
      cmp("mode", mode, mSt);
      cmp("ecCount", ecCount, mEc);
      cmp("ecOvf", ecOvf, mOvf);
      cmp("rail1En", rail1En, (mSt == 4 || mSt == 5));
      cmp("rail2En", rail2En, (mSt == 5 || (mSt == 4 && mStep >= 1)));
      cmp("boostEn", boostEn, (mSt == 5 || (mSt == 4 && mStep >= 1)));
      cmp("rail3En", rail3En, (mSt == 5 || (mSt == 4 && mStep == 2)));
      cmp("resetN", resetN, (mSt == 5 && mHold == 0));
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; cyc(1); s = 0;
  endtask

  // from SELFTEST_ALL up to ACTIVE
  task automatic bringUp();
    wake = 1; vtLow = 0; vtHigh = 0; rail1Ok = 1;
    ovFlags = '1; uvFlags = '1; cyc(2);
    ovFlags = '0; uvFlags = '0; cyc(30);
  endtask

  initial begin
    cyc(3);
    curReq = "R1";
    cmp("mode in reset", mode, 0);
    cmp("rail1En in reset", rail1En, 0);
    cmp("resetN in reset", resetN, 0);
    cmp("ecCount in reset", ecCount, 0);
    rst_n = 1; chkEn = 1;
    cyc(2); cmp("INIT hold", mode, 0);
    cfgOk = 1; vregUvSelf = 1; cyc(2); cmp("to SELFTEST_ALL", mode, 1);

    curReq = "R2"; wake = 1;
    ovFlags = '1; cyc(5); cmp("partial pattern", mode, 1);
    uvFlags = '1; cyc(2); cmp("full pattern", mode, 2);

    curReq = "R3"; vtLow = 1;
    cyc(5); cmp("ov holds", mode, 2);
    ovFlags = '0; overTemp = 1; cyc(5); cmp("ot holds", mode, 2);
    overTemp = 0; cyc(2); cmp("to TEMPCHECK", mode, 3);
    uvFlags = '0;

    curReq = "R4";
    cyc(START_TMO + 10); cmp("timeout with wake high", mode, 3);
    wake = 0; cyc(2); cmp("timeout to SLEEP", mode, 7);

    curReq = "R12";
    wake = 1; cyc(2); wake = 0; cyc(3); cmp("short wake", mode, 7);
    wake = 1; cyc(WAKE_MIN + 2); cmp("long wake", mode, 1);

    curReq = "R5";
    ovFlags = '1; uvFlags = '1; cyc(2); ovFlags = '0; cyc(2); uvFlags = '0;
    cmp("in TEMPCHECK", mode, 3);
    gndLoss = 1; cyc(1);
    curReq = "R7";
    cmp("fault entry", mode, 6); cmp("ec inc", ecCount, 1);
    gndLoss = 0; cyc(2); cmp("fault exit", mode, 1);

    curReq = "R6";
    ovFlags = '1; uvFlags = '1; cyc(2); ovFlags = '0; uvFlags = '0; cyc(2);
    rail1Ok = 0; vtLow = 0; cyc(2); cmp("RAMP", mode, 4);
    cyc(SEQ2_DLY + 5); cmp("rail2 waits for rail1", rail2En, 0);
    cmp("rail1 on", rail1En, 1);
    rail1Ok = 1; cyc(2); cmp("rail2 on", rail2En, 1); cmp("rail3 off", rail3En, 0);
    cyc(SEQ1_DLY + 3); cmp("ACTIVE", mode, 5);
    curReq = "R14";
    cmp("reset held", resetN, 0);
    cyc(RST_HOLD + 2); cmp("reset released", resetN, 1);

    curReq = "R10";
    pulse(wdViol); cmp("wd keeps ACTIVE", mode, 5); cmp("wd inc", ecCount, 2);
    cmp("wd re-holds reset", resetN, 0);
    cyc(RST_HOLD + 2);

    curReq = "R9";
    pulse(cmdSleep); cmp("sleep cmd", mode, 7); cmp("ec dec", ecCount, 1);
    cyc(2); bringUp();

    curReq = "R11";
    pulse(vtLow); cmp("vtLow in ACTIVE", mode, 1);
    ovFlags = '1; uvFlags = '1; cyc(2); ovFlags = '0; uvFlags = '0; cyc(4);
    cmp("RAMP again", mode, 4);
    pulse(vtHigh); cmp("vtHigh in RAMP", mode, 1);
    bringUp();

    curReq = "R8";
    pulse(gndLoss); cmp("fault 2", ecCount, 2);
    cyc(2); bringUp();
    pulse(wdViol); cmp("wd to 3", ecCount, 3);
    cyc(3);
    pulse(wdViol); cmp("limit to SLEEP", mode, 7);
    cmp("limit clears ec", ecCount, 0); cmp("ovf set", ecOvf, 1);
    pulse(ovfRead); cmp("ovf cleared", ecOvf, 0);
    cyc(2); bringUp();

    curReq = "R9";
    pulse(cmdLock); cmp("LOCKED", mode, 8);
    curReq = "R12";
    cyc(20); cmp("wake ignored in LOCKED", mode, 8);

    curReq = "R13";
    porReq = 1; cyc(2); cmp("SHUTDOWN", mode, 9); cmp("cold clears ec", ecCount, 0);
    porReq = 0; cyc(1); cmp("to INIT", mode, 0);
    cyc(1); cmp("restart", mode, 1);

    curReq = "R4";
    wake = 0; cyc(START_TMO + 3); cmp("SELFTEST_ALL timeout", mode, 7);
    curReq = "R13";
    pulse(lpClkLost); cmp("clock loss", mode, 9);
    cyc(3);

    curReq = "R7";
    bringUp();
    pulse(thermShut); cyc(3);
    wake = 1; ovFlags = '1; uvFlags = '1; cyc(2); ovFlags = '0; uvFlags = '0; cyc(4);
    cmp("RAMP for fault", mode, 4);
    ovFlags[2] = 1; cyc(1); cmp("RAMP fault", mode, 6); ovFlags = '0;
    cyc(5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule